// File: doc/BRIEF.md
# SPI Controller Control Register

This block is the control register of a small SPI controller that sits on a processor-style memory-mapped bus. It is one register wide, eight bits by default. It holds the divider code for the serial clock, the index of the peripheral to address, a device-enable bit, an interrupt-enable bit, and a completion flag. The shifter can set the completion flag on its own, whatever the bus is doing in that cycle.

Every field is always present on dedicated outputs for the rest of the controller. The shared data bus, by contrast, is driven only during an addressed read. The data goes out on a read-data output together with an output-enable that controls the external tri-state buffer. The block also decodes the peripheral index into active-low chip selects. The decode is gated by the enable bit, so the all-zero state after reset leaves every peripheral idle. An active-low interrupt request is raised when a completion is pending and interrupts are enabled.

Register layout, from the most significant bit down: completion flag (bit 7), spare bit that always reads 0 (bit 6), interrupt enable (bit 5), device enable (bit 4), device index (bits 3:2), divider code (bits 1:0).

Top module: `spi_ctrl_reg`

## Requirements
- R1: While `rst_n` is low, all eight register bits are 0. As a result, every field output is 0, `cs_n` is 4'b1111 and `irq_n` is 1.
- R2: A write happens at a rising clock edge when `reg_sel` and `wr_en` are both high. It loads bits 5:0 of `wdata` into the interrupt enable, device enable, device index and divider fields. Without such a write, those fields keep their values.
- R3: Bit 6 always reads back as 0, and writing 1 to it has no effect.
- R4: When `shift_done` is high at a clock edge, the completion flag is 1 after that edge. This holds even if the same edge carries a write of 0 to bit 7.
- R5: A write with bit 7 = 0 and no `shift_done` clears the completion flag. A write with bit 7 = 1 sets it.
- R6: `rdata_oe` is high only when `reg_sel` and `rd_en` are high and `wr_en` is low. `rdata` then carries the full stored register value, and it is 0 at all other times.
- R7: When device enable (bit 4) is 1, exactly one bit of `cs_n` is low: bit N, where N is the device index in bits 3:2 (0 to 3). When device enable is 0, all four bits are high.
- R8: `irq_n` is low exactly when both interrupt enable (bit 5) and the completion flag (bit 7) are 1.
- R9: `div_sel`, `dev_sel`, `dev_en`, `irq_en` and `xfer_done` show the stored fields at all times, whatever the state of the bus signals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select strobe from the address decoder |
| wr_en | input | 1 | Bus write qualifier |
| rd_en | input | 1 | Bus read qualifier |
| wdata | input | 8 | Write data from the bus |
| shift_done | input | 1 | Transfer-complete strobe from the shifter |
| rdata | output | 8 | Read data towards the bus driver |
| rdata_oe | output | 1 | Output enable for the bus driver |
| div_sel | output | 2 | Serial clock divider code |
| dev_sel | output | 2 | Selected peripheral index |
| dev_en | output | 1 | Device enable field |
| irq_en | output | 1 | Interrupt enable field |
| xfer_done | output | 1 | Completion flag |
| cs_n | output | 4 | Active-low chip selects |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default parameters: a 2-bit divider field and four peripherals, which gives the 8-bit layout above. With these values, the random phase reaches every device index, both states of the enable bits, and collisions between `shift_done` and bus writes. Directed cycles cover the corner cases: writes to the spare bit, a write of 0 racing a completion, and reads without select.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } bus_op_e;

  // Writes take precedence over reads when both qualifiers are raised.
  function automatic bus_op_e decode_op(input logic sel, input logic wr, input logic rd);
    if (!sel)    return BUS_IDLE;
    if (wr)      return BUS_WRITE;
    if (rd)      return BUS_READ;
    return BUS_IDLE;
  endfunction

endpackage

// File: rtl/ctrl_fields.sv
module ctrl_fields #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2: fields hold without a write
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/done_flag.sv
module done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_bit,
  input  logic hw_set,
  output logic flag
);

  logic flag_nxt;

  // Hardware set is applied last so a completion is never lost.
  always_comb begin
    flag_nxt = flag;
    if (sw_wr)  flag_nxt = sw_bit;
    if (hw_set) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nxt;
  end

  p_hw_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag);

  p_sw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_bit && !hw_set) |=> !flag);

  p_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_bit) |=> flag);

endmodule

// File: rtl/cs_decode.sv
module cs_decode #(
  parameter int NUM_DEV = 4,
  parameter int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   idx,
  output logic [NUM_DEV-1:0] cs_n
);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_line
    assign cs_n[d] = ~(en && (idx == SEL_W'(d)));
  end

endmodule

// File: rtl/rd_driver.sv
module rd_driver #(
  parameter int W = 8
) (
  input  logic         rd,
  input  logic [W-1:0] value,
  output logic [W-1:0] rdata,
  output logic         oe
);

  always_comb begin
    oe    = rd;
    rdata = rd ? value : '0;
  end

endmodule

// File: rtl/spi_ctrl_reg.sv
module spi_ctrl_reg #(
  parameter int DIV_W   = 2,
  parameter int NUM_DEV = 4,
  localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int REG_W  = DIV_W + SEL_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [REG_W-1:0]   wdata,
  input  logic               shift_done,
  output logic [REG_W-1:0]   rdata,
  output logic               rdata_oe,
  output logic [DIV_W-1:0]   div_sel,
  output logic [SEL_W-1:0]   dev_sel,
  output logic               dev_en,
  output logic               irq_en,
  output logic               xfer_done,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               irq_n
);
  import spi_ctrl_pkg::*;

  localparam int LOW_W   = REG_W - 2;
  localparam int SEL_LSB = DIV_W;
  localparam int DEN_POS = DIV_W + SEL_W;
  localparam int IEN_POS = DEN_POS + 1;
  localparam int SPR_POS = REG_W - 2;
  localparam int DON_POS = REG_W - 1;

  bus_op_e          op;
  logic             do_wr;
  logic             do_rd;
  logic [LOW_W-1:0] low_q;
  logic [REG_W-1:0] reg_view;
  logic             unused_spare;

  assign op           = decode_op(reg_sel, wr_en, rd_en);
  assign do_wr        = (op == BUS_WRITE);
  assign do_rd        = (op == BUS_READ);
  assign unused_spare = wdata[SPR_POS];

  ctrl_fields #(.W(LOW_W)) u_fields (
    .clk  (clk),
    .rst_n(rst_n),
    .load (do_wr),
    .din  (wdata[LOW_W-1:0]),
    .q    (low_q)
  );

  done_flag u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_wr (do_wr),
    .sw_bit(wdata[DON_POS]),
    .hw_set(shift_done),
    .flag  (xfer_done)
  );

  assign div_sel  = low_q[DIV_W-1:0];
  assign dev_sel  = low_q[SEL_LSB +: SEL_W];
  assign dev_en   = low_q[DEN_POS];
  assign irq_en   = low_q[IEN_POS];
  assign reg_view = {xfer_done, 1'b0, low_q};

  cs_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_cs (
    .en  (dev_en),
    .idx (dev_sel),
    .cs_n(cs_n)
  );

  rd_driver #(.W(REG_W)) u_rd (
    .rd   (do_rd),
    .value(reg_view),
    .rdata(rdata),
    .oe   (rdata_oe)
  );

  assign irq_n = ~(irq_en & xfer_done);

  p_spare_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[SPR_POS] == 1'b0);

  p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));

  p_oe_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (reg_sel && rd_en && !wr_en));

  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_en |-> (cs_n == '1));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (irq_en && xfer_done));

endmodule

// File: tb/sim_spi_ctrl_reg.sv
module sim_spi_ctrl_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, wr_en, rd_en, shift_done;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic [1:0] div_sel, dev_sel;
  logic       dev_en, irq_en, xfer_done, irq_n;
  logic [3:0] cs_n;

  int vectors = 0;
  int misses  = 0;
  bit over    = 0;
  logic [7:0] mdl;

  always #2.5 clk = ~clk;

  spi_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .shift_done(shift_done), .rdata(rdata), .rdata_oe(rdata_oe),
    .div_sel(div_sel), .dev_sel(dev_sel), .dev_en(dev_en), .irq_en(irq_en),
    .xfer_done(xfer_done), .cs_n(cs_n), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the behavioural model state plus live inputs.
  task automatic compare();
    logic       oe_e;
    logic [3:0] cs_e;
    oe_e = reg_sel && rd_en && !wr_en;
    cs_e = mdl[4] ? ~(4'b0001 << mdl[3:2]) : 4'b1111;
    chk("R6 oe", {31'b0, rdata_oe}, {31'b0, oe_e});
    chk("R6/R3 rdata", {24'b0, rdata}, oe_e ? {24'b0, mdl} : 32'b0);
    chk("R7 cs_n", {28'b0, cs_n}, {28'b0, cs_e});
    chk("R8 irq_n", {31'b0, irq_n}, {31'b0, ~(mdl[5] & mdl[7])});
    chk("R2/R9 fields", {26'b0, irq_en, dev_en, dev_sel, div_sel}, {26'b0, mdl[5:0]});
    chk("R4/R5 flag", {31'b0, xfer_done}, {31'b0, mdl[7]});
  endtask

  task automatic cyc(input logic s, input logic w, input logic r,
                     input logic [7:0] d, input logic hs);
    reg_sel = s; wr_en = w; rd_en = r; wdata = d; shift_done = hs;
    #1 compare();
    @(posedge clk);
    if (s && w) mdl = {d[7], 1'b0, d[5:0]};
    if (hs) mdl[7] = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mdl = 8'h00;
    #1 compare();              // R1: cleared asynchronously
    chk("R1 cs_n", {28'b0, cs_n}, 32'hF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!over) begin
      misses++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    reg_sel = 0; wr_en = 0; rd_en = 0; wdata = 0; shift_done = 0; rst_n = 0;
    mdl = 8'h00;
    @(negedge clk);
    do_reset();                                  // R1
    cyc(1, 0, 1, 8'h00, 0);                      // R1 read of reset value
    for (int i = 0; i < 4; i++) begin            // R7 each device
      cyc(1, 1, 0, 8'h10 | 8'(i << 2) | 8'(i), 0);
      cyc(1, 0, 1, 8'h00, 0);
    end
    cyc(1, 1, 0, 8'h0C, 0);                      // R7 disabled: all high
    cyc(0, 1, 0, 8'h3F, 0);                      // R2 no select: ignored
    cyc(1, 1, 0, 8'h7F, 0);                      // R3 spare bit written as 1
    cyc(1, 0, 1, 8'h00, 0);                      // R3 reads 0
    cyc(1, 1, 0, 8'h20, 1);                      // R4 hw set beats write of 0
    cyc(1, 0, 1, 8'h00, 0);                      // R8 irq low
    cyc(1, 1, 0, 8'h20, 0);                      // R5 clear
    cyc(1, 1, 0, 8'hA0, 0);                      // R5 software set
    cyc(0, 0, 1, 8'h00, 0);                      // R6 read without select
    cyc(1, 1, 1, 8'h00, 0);                      // R6 write wins over read
    cyc(0, 0, 0, 8'h00, 1);                      // R4 set while idle
    cyc(1, 0, 0, 8'h00, 0);                      // R9 fields still visible
    for (int i = 0; i < 3000; i++) begin
      cyc(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
          ($urandom % 5) == 0);
      if (i == 1500) do_reset();                 // R1 mid-run
    end
    over = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule